// File: doc/BRIEF.md
# Prioritized Channel-Mapped Interrupt Controller

The controller collects up to 32 interrupt request lines. Software programs two bits per line: the active polarity and the choice between edge and level detection. Edge lines pass through a synchronizer and set a sticky pending flag on the chosen transition. Level lines make the pending flag track the active level.

Each line carries one byte that names a host channel from 0 to 31. A lower channel number means a higher priority. Channels 0 and 1 feed a fast host output. Channels 2 to 31 feed a normal host output. A read-only register reports which pending, enabled line currently wins arbitration. Software uses this register to decide which source to service. It then clears that source by writing its index to an index-clear register.

All registers sit on a simple single-cycle word-addressed write bus with a combinational read. A global enable and two per-output host enables gate the outputs.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Bit i of register 0x0B (polarity) and bit i of register 0x0C (type) select the mode of line i. Type 1 with polarity 1 latches on a rising edge. Type 1 with polarity 0 latches on a falling edge. Type 0 with polarity 1 tracks an active-high level. Type 0 with polarity 0 tracks an active-low level.
- R2: The pending word is read at 0x08. Writing N below 32 to 0x09 clears only the pending bit of line N. Writing a mask to 0x0A clears every pending bit whose mask bit is 1. An edge-latched bit stays set until it is cleared. A level line's bit comes back while its level stays active. Writing an index of 32 or more has no effect.
- R3: The enable word is read at 0x04. Writing N below 32 to 0x05 sets only enable bit N. Writing N to 0x06 clears only enable bit N.
- R4: Writing a mask to 0x07 clears every enable bit whose mask bit is 1 and leaves the other bits unchanged.
- R5: Channel-map word w sits at address 0x10+w. Line 4w+k uses bits 8k+7:8k of that word, and the word reads back as written.
- R6: Register 0x0D returns the index of the winning line among those that are both pending and enabled. The lowest channel wins, and a tie goes to the lowest line index. The register reads 0xFFFFFFFF when no line qualifies. Enable bits and pending bits are both required.
- R7: The fast output is high when any pending, enabled line maps to channel 0 or 1. The normal output is high when any such line maps to channels 2 to 31. A map byte of 32 or more routes the line to neither output.
- R8: While bit 0 of register 0x00 (global enable) is 0, both host outputs are 0.
- R9: The host enables read at 0x01 in bits 1:0. Writing 0 or 1 to 0x02 sets one host enable, and writing 0 or 1 to 0x03 clears one. Index 0 gates the fast output and index 1 gates the normal output.
- R10: After reset, all enables, pending bits, polarity and type bits are 0. Every map byte is 0x0F, and the winner register reads 0xFFFFFFFF.
- R11: A change on an input line shows in its pending bit after the third rising clock edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_in | input | NUM_SRC | Interrupt request lines, asynchronous |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| host_fast_o | output | 1 | Fast host request (channels 0-1) |
| host_norm_o | output | 1 | Normal host request (channels 2-31) |

## Verification
The detection modes are driven with all four polarity and type combinations at once, one per line in a repeating pattern. Level steps and edge steps then tell tracking apart from latching and rising from falling. The index-clear and index-set registers are swept over every line, with an out-of-range index added, so that a clear or set touching a neighbour bit is exposed. Arbitration uses a map in which line pairs share a channel. Winners are cleared one by one until none are left, which separates channel order from index order. A single routed line is moved through channels 0 to 33, which finds the fast/normal boundary and the unrouted values.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int ADDR_W   = 6;
  localparam int DATA_W   = 32;
  localparam int CHAN_W   = 8;
  localparam int FAST_CHANS = 2;

  localparam logic [ADDR_W-1:0] A_GLB      = 6'h00;
  localparam logic [ADDR_W-1:0] A_HEN      = 6'h01;
  localparam logic [ADDR_W-1:0] A_HEN_SET  = 6'h02;
  localparam logic [ADDR_W-1:0] A_HEN_CLR  = 6'h03;
  localparam logic [ADDR_W-1:0] A_EN       = 6'h04;
  localparam logic [ADDR_W-1:0] A_EN_SET   = 6'h05;
  localparam logic [ADDR_W-1:0] A_EN_CLR   = 6'h06;
  localparam logic [ADDR_W-1:0] A_EN_BCLR  = 6'h07;
  localparam logic [ADDR_W-1:0] A_PEND     = 6'h08;
  localparam logic [ADDR_W-1:0] A_PEND_CLR = 6'h09;
  localparam logic [ADDR_W-1:0] A_PEND_BCLR= 6'h0A;
  localparam logic [ADDR_W-1:0] A_POL      = 6'h0B;
  localparam logic [ADDR_W-1:0] A_TYP      = 6'h0C;
  localparam logic [ADDR_W-1:0] A_WIN      = 6'h0D;
  localparam int                A_MAP      = 16;

  localparam logic [CHAN_W-1:0] CHAN_RST = 8'h0F;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic pol_i,
  input  logic type_i,
  input  logic clr_i,
  output logic pend_o
);
  logic sync1_q, sync2_q, prev_q, pend_q;
  logic pend_d, edge_hit, lvl_act;

  always_comb begin
    edge_hit = pol_i ? (sync2_q & ~prev_q) : (~sync2_q & prev_q);
    lvl_act  = ~(sync2_q ^ pol_i);
    if (type_i) pend_d = (pend_q & ~clr_i) | edge_hit;
    else        pend_d = lvl_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      sync1_q <= src_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      pend_q  <= pend_d;
    end
  end

  assign pend_o = pend_q;

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (type_i && pend_q && !clr_i) |=> pend_q); // R2
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CHAN = 32,
  parameter int CHAN_W   = 8,
  localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]             act_i,
  input  logic [NUM_SRC-1:0][CHAN_W-1:0] map_i,
  output logic                           vld_o,
  output logic [IDX_W-1:0]               idx_o,
  output logic [CHAN_W-1:0]              chan_o
);
  always_comb begin
    vld_o  = 1'b0;
    idx_o  = '0;
    chan_o = CHAN_W'(NUM_CHAN);
    for (int i = 0; i < NUM_SRC; i++) begin
      if (act_i[i] && (map_i[i] < chan_o)) begin
        vld_o  = 1'b1;
        idx_o  = IDX_W'(i);
        chan_o = map_i[i];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CHAN = 32,
  localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int MAP_WORDS = (NUM_SRC + 3) / 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               host_fast_o,
  output logic               host_norm_o
);
  // reset: asynchronous assert, synchronous release
  logic rst_s1_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_q    <= rst_s1_q;
    end
  end

  logic                           glb_q, glb_d;
  logic [1:0]                     hen_q, hen_d;
  logic [NUM_SRC-1:0]             en_q, en_d, pol_q, pol_d, typ_q, typ_d;
  logic [NUM_SRC-1:0][CHAN_W-1:0] map_q, map_d;
  logic [NUM_SRC-1:0]             clr_vec, pend, act;
  logic                           idx_ok, hidx_ok;
  logic [IDX_W-1:0]               widx;

  assign widx    = bus_wdata[IDX_W-1:0];
  assign idx_ok  = (bus_wdata < DATA_W'(NUM_SRC));
  assign hidx_ok = (bus_wdata < 32'd2);

  // next-state of the register file
  always_comb begin
    glb_d   = glb_q;
    hen_d   = hen_q;
    en_d    = en_q;
    pol_d   = pol_q;
    typ_d   = typ_q;
    map_d   = map_q;
    clr_vec = '0;
    if (bus_we) begin
      case (bus_addr)
        A_GLB:       glb_d = bus_wdata[0];
        A_HEN_SET:   if (hidx_ok) hen_d[bus_wdata[0]] = 1'b1;
        A_HEN_CLR:   if (hidx_ok) hen_d[bus_wdata[0]] = 1'b0;
        A_EN_SET:    if (idx_ok) en_d[widx] = 1'b1;
        A_EN_CLR:    if (idx_ok) en_d[widx] = 1'b0;
        A_EN_BCLR:   en_d = en_q & ~bus_wdata[NUM_SRC-1:0];
        A_PEND_CLR:  if (idx_ok) clr_vec[widx] = 1'b1;
        A_PEND_BCLR: clr_vec = bus_wdata[NUM_SRC-1:0];
        A_POL:       pol_d = bus_wdata[NUM_SRC-1:0];
        A_TYP:       typ_d = bus_wdata[NUM_SRC-1:0];
        default: begin
          for (int w = 0; w < MAP_WORDS; w++) begin
            if (bus_addr == ADDR_W'(A_MAP + w)) begin
              for (int b = 0; b < 4; b++) begin
                if (w * 4 + b < NUM_SRC) map_d[w*4+b] = bus_wdata[8*b +: 8];
              end
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      glb_q <= 1'b0;
      hen_q <= '0;
      en_q  <= '0;
      pol_q <= '0;
      typ_q <= '0;
      map_q <= {NUM_SRC{CHAN_RST}};
    end else if (bus_we) begin
      glb_q <= glb_d;
      hen_q <= hen_d;
      en_q  <= en_d;
      pol_q <= pol_d;
      typ_q <= typ_d;
      map_q <= map_d;
    end
  end

  // per-line detection
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_src_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_q),
      .src_i  (src_in[g]),
      .pol_i  (pol_q[g]),
      .type_i (typ_q[g]),
      .clr_i  (clr_vec[g]),
      .pend_o (pend[g])
    );
  end

  assign act = pend & en_q;

  // host routing
  logic [NUM_SRC-1:0] to_fast, to_norm;
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_route
    assign to_fast[g] = act[g] && (map_q[g] < CHAN_W'(FAST_CHANS));
    assign to_norm[g] = act[g] && (map_q[g] >= CHAN_W'(FAST_CHANS))
                               && (map_q[g] < CHAN_W'(NUM_CHAN));
  end

  assign host_fast_o = glb_q & hen_q[0] & (|to_fast);
  assign host_norm_o = glb_q & hen_q[1] & (|to_norm);

  // arbitration
  logic              win_vld;
  logic [IDX_W-1:0]  win_idx;
  logic [CHAN_W-1:0] win_chan;

  irq_prio_arb #(.NUM_SRC(NUM_SRC), .NUM_CHAN(NUM_CHAN), .CHAN_W(CHAN_W)) u_arb (
    .act_i  (act),
    .map_i  (map_q),
    .vld_o  (win_vld),
    .idx_o  (win_idx),
    .chan_o (win_chan)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_GLB:  bus_rdata[0]   = glb_q;
      A_HEN:  bus_rdata[1:0] = hen_q;
      A_EN:   bus_rdata[NUM_SRC-1:0] = en_q;
      A_PEND: bus_rdata[NUM_SRC-1:0] = pend;
      A_POL:  bus_rdata[NUM_SRC-1:0] = pol_q;
      A_TYP:  bus_rdata[NUM_SRC-1:0] = typ_q;
      A_WIN:  bus_rdata = win_vld ? DATA_W'(win_idx) : '1;
      default: begin
        for (int w = 0; w < MAP_WORDS; w++) begin
          if (bus_addr == ADDR_W'(A_MAP + w)) begin
            for (int b = 0; b < 4; b++) begin
              if (w * 4 + b < NUM_SRC) bus_rdata[8*b +: 8] = map_q[w*4+b];
            end
          end
        end
      end
    endcase
  end

  AST_GLB_GATE: assert property (@(posedge clk) disable iff (!rst_q)
    !glb_q |-> (!host_fast_o && !host_norm_o)); // R8
  AST_FAST_WIN: assert property (@(posedge clk) disable iff (!rst_q)
    host_fast_o |-> (win_vld && win_chan < CHAN_W'(FAST_CHANS))); // R7
  AST_NORM_WIN: assert property (@(posedge clk) disable iff (!rst_q)
    host_norm_o |-> win_vld); // R7
  AST_WIN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_q)
    win_vld |-> (pend[win_idx] && en_q[win_idx])); // R6
  AST_IDX_SET: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && bus_addr == A_EN_SET && idx_ok) |=> en_q[$past(widx)]); // R3
endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src_in;
  logic        bus_we;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        host_fast_o, host_norm_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  logic [7:0]  chan_m [32];
  logic [31:0] rv;

  always #2 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .host_fast_o(host_fast_o), .host_norm_o(host_norm_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_win(input logic [31:0] act);
    int best = 99;
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int i = 0; i < 32; i++)
      if (act[i] && chan_m[i] < 32 && int'(chan_m[i]) < best) begin
        best = int'(chan_m[i]);
        r = 32'(i);
      end
    return r;
  endfunction

  task automatic pend_all();
    src_in = '0; settle();
    src_in = '1; settle();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] e, act, w;
    rst_n = 1'b0; src_in = '1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R10 reset state
    rd(6'h00, rv); check("R10 glb", rv, 0);
    rd(6'h01, rv); check("R10 hen", rv, 0);
    rd(6'h04, rv); check("R10 en", rv, 0);
    rd(6'h08, rv); check("R10 pend", rv, 0);
    rd(6'h0B, rv); check("R10 pol", rv, 0);
    rd(6'h0C, rv); check("R10 typ", rv, 0);
    rd(6'h0D, rv); check("R10 win", rv, 32'hFFFF_FFFF);
    for (int k = 0; k < 8; k++) begin
      rd(6'(16 + k), rv); check("R10 map", rv, 32'h0F0F_0F0F);
    end
    check("R10 outs", {30'd0, host_fast_o, host_norm_o}, 0);

    // R1 all four modes, line i uses pol=i[0], typ=i[1]
    wr(6'h0B, 32'hAAAA_AAAA); wr(6'h0C, 32'hCCCC_CCCC); settle();
    wr(6'h0A, 32'hFFFF_FFFF); settle();
    e = 0; for (int i = 0; i < 32; i++) if (i % 4 == 1) e[i] = 1'b1;
    rd(6'h08, rv); check("R1 idle high", rv, e);
    src_in = '0; settle();
    e = 0; for (int i = 0; i < 32; i++) if (i % 4 == 0 || i % 4 == 2) e[i] = 1'b1;
    rd(6'h08, rv); check("R1 after fall", rv, e);
    src_in = '1; settle();
    e = 0; for (int i = 0; i < 32; i++) if (i % 4 != 0) e[i] = 1'b1;
    rd(6'h08, rv); check("R1 after rise", rv, e);
    wr(6'h09, 32'd1); settle();
    rd(6'h08, rv); check("R2 level reasserts", rv, e);

    // R2 index clear sweep
    wr(6'h0B, '1); wr(6'h0C, '1); wr(6'h0A, '1);
    pend_all();
    rd(6'h08, rv); check("R2 all pending", rv, '1);
    wr(6'h09, 32'd32);
    rd(6'h08, rv); check("R2 out-of-range idx", rv, '1);
    for (int n = 0; n < 32; n++) begin
      wr(6'h09, 32'(n));
      rd(6'h08, rv); check("R2 idx clear", rv, 32'(64'hFFFF_FFFF << (n + 1)));
    end
    pend_all();
    wr(6'h0A, 32'h0FF0_00F0);
    rd(6'h08, rv); check("R2 bulk clear", rv, 32'hF00F_FF0F);

    // R3 enable index set/clear, R4 bulk clear
    e = 0;
    for (int n = 0; n < 32; n++) begin
      wr(6'h05, 32'(n)); e[n] = 1'b1;
      rd(6'h04, rv); check("R3 idx set", rv, e);
    end
    for (int n = 0; n < 32; n += 2) wr(6'h06, 32'(n));
    wr(6'h06, 32'd40);
    rd(6'h04, rv); check("R3 idx clear", rv, 32'hAAAA_AAAA);
    wr(6'h07, 32'hFFFF_0000);
    rd(6'h04, rv); check("R4 bulk clear", rv, 32'h0000_AAAA);
    wr(6'h07, '1);
    rd(6'h04, rv); check("R4 bulk clear all", rv, 0);

    // R5 map layout, R6 arbitration
    for (int i = 0; i < 32; i++) chan_m[i] = 8'((i * 13 + 5) % 16);
    for (int k = 0; k < 8; k++)
      wr(6'(16 + k), {chan_m[4*k+3], chan_m[4*k+2], chan_m[4*k+1], chan_m[4*k]});
    for (int k = 0; k < 8; k++) begin
      rd(6'(16 + k), rv);
      check("R5 map readback", rv, {chan_m[4*k+3], chan_m[4*k+2], chan_m[4*k+1], chan_m[4*k]});
    end
    pend_all();
    rd(6'h0D, rv); check("R6 none enabled", rv, 32'hFFFF_FFFF);
    for (int n = 0; n < 32; n++) wr(6'h05, 32'(n));
    act = '1;
    for (int k = 0; k < 32; k++) begin
      w = exp_win(act);
      rd(6'h0D, rv); check("R6 winner", rv, w);
      wr(6'h09, w); act[w[4:0]] = 1'b0;
    end
    rd(6'h0D, rv); check("R6 empty", rv, 32'hFFFF_FFFF);
    pend_all(); act = '1;
    w = exp_win(act);
    wr(6'h06, w); act[w[4:0]] = 1'b0;
    rd(6'h0D, rv); check("R6 disabled skipped", rv, exp_win(act));

    // R7 routing, R8 global, R9 host enables
    wr(6'h07, '1); wr(6'h05, 32'd0);
    wr(6'h00, 32'd1); wr(6'h02, 32'd0); wr(6'h02, 32'd1);
    rd(6'h01, rv); check("R9 hen set", rv, 32'd3);
    for (int c = 0; c < 34; c++) begin
      wr(6'h10, {24'h0F0F0F, 8'(c)});
      check("R7 fast", {31'd0, host_fast_o}, (c < 2) ? 1 : 0);
      check("R7 norm", {31'd0, host_norm_o}, (c >= 2 && c < 32) ? 1 : 0);
    end
    wr(6'h10, 32'h0F0F_0F01);
    wr(6'h00, 32'd0);
    check("R8 gated", {30'd0, host_fast_o, host_norm_o}, 0);
    wr(6'h00, 32'd1);
    check("R8 released", {30'd0, host_fast_o, host_norm_o}, 32'd2);
    wr(6'h03, 32'd0);
    check("R9 fast gated", {30'd0, host_fast_o, host_norm_o}, 0);
    wr(6'h10, 32'h0F0F_0F03);
    check("R9 norm on", {30'd0, host_fast_o, host_norm_o}, 32'd1);
    wr(6'h03, 32'd1);
    check("R9 norm gated", {30'd0, host_fast_o, host_norm_o}, 0);
    wr(6'h02, 32'd5);
    rd(6'h01, rv); check("R9 bad idx ignored", rv, 0);

    // R11 latency on line 5 (rising edge mode)
    src_in[5] = 1'b0; settle();
    wr(6'h0A, '1);
    src_in[5] = 1'b1;
    @(negedge clk); rd(6'h08, rv); check("R11 edge1", rv, 0);
    @(negedge clk); rd(6'h08, rv); check("R11 edge2", rv, 0);
    @(negedge clk); rd(6'h08, rv); check("R11 edge3", rv, 32'h20);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule